// File: doc/BRIEF.md
# GMII Receive Payload and Frame Check Extractor

This block watches the byte-wide receive side of a gigabit media-independent interface and splits every frame into its payload and its trailing four-byte frame check sequence (FCS). The frame length is never known in advance. Instead, a qualified-valid flag and the receive byte both pass through a four-stage delay line. A byte leaving the delay line is payload while the live flag is still high. It is an FCS byte once the live flag has dropped and the delayed flag has not yet followed.

The extracted payload goes out on a byte stream and also feeds a CRC-32 accumulator. After the last FCS byte, the accumulated checksum is compared with the captured FCS. When enabled, each payload byte is also compared with a reference byte that the user supplies in the same cycle. Two active-low error flags record the results, and a third output is low when either flag is low. The flags hold their value until the next frame begins.

Top module: `gmii_rx_extract`

## Requirements
- R1: A frame is tracked only if its first byte with `rx_dv` high is 0x55. Bytes at frame index below `SKIP_BYTES` (default 8, covering preamble and start delimiter) are never extracted. A frame whose first byte is not 0x55 produces no `pld_vld` and no `chk_done`.
- R2: A payload byte is a byte at index i with `SKIP_BYTES` <= i <= length-5. If it is on `rxd` at clock edge t, it appears on `pld_byte` with `pld_vld` high for exactly the cycle after edge t+5.
- R3: The last four bytes of a tracked frame never appear with `pld_vld` high. A frame holding exactly four bytes after the skipped header produces no payload.
- R4: The checksum is CRC-32 with reflected polynomial 0xEDB88320, initial value all ones and final inversion, taken over the payload bytes. The received FCS arrives least-significant byte of the inverted CRC first. If the last FCS byte is on `rxd` at edge L, `chk_done` is high for one cycle after edge L+6. `crc_err_n` takes its new value at that same edge: 1 on a match, 0 on a mismatch.
- R5: When `ref_en` and `pld_vld` are both high at an edge and `ref_byte` differs from `pld_byte`, `data_err_n` is 0 after that edge.
- R6: While `ref_en` is low, `ref_byte` has no effect on `data_err_n`.
- R7: `err_n` is low whenever `crc_err_n` or `data_err_n` is low.
- R8: Both error flags hold their value until the first byte (0x55) of the next tracked frame. They return to 1 on the edge after that byte is registered, so they are high when that frame's first payload byte comes out.
- R9: After reset, `pld_vld` and `chk_done` are 0 and `crc_err_n`, `data_err_n` and `err_n` are 1.
- R10: For a frame with an empty payload, the check is still made. An FCS of four 0x00 bytes is then a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid from the line |
| rxd | input | 8 | Receive byte from the line |
| ref_en | input | 1 | Enables comparison against the reference stream |
| ref_byte | input | 8 | Reference byte, sampled while `pld_vld` is high |
| pld_vld | output | 1 | Payload byte valid |
| pld_byte | output | 8 | Extracted payload byte |
| chk_done | output | 1 | One-cycle pulse when the checksum verdict is updated |
| crc_err_n | output | 1 | Low when the last checksum mismatched |
| data_err_n | output | 1 | Low when the payload differed from the reference |
| err_n | output | 1 | Low when either error flag is low |

## Verification
A wrong header count, or a delay line of the wrong depth, shifts the payload window. It shows within six cycles of the first payload byte: `pld_vld` covers the wrong bytes, or it covers FCS bytes at the end of a frame. An accumulator that misses or adds a byte, or an FCS register filled in the wrong order, gives a wrong verdict at `chk_done`. That pulse comes six cycles after the frame ends. Stale error state shows at the first payload byte of the next frame, when both flags must already be high again.

// File: rtl/gmii_rx_pkg.sv
package gmii_rx_pkg;
  localparam int BYTE_W     = 8;
  localparam int CRC_W      = 32;
  localparam int TAIL_BYTES = CRC_W / BYTE_W;
  localparam logic [BYTE_W-1:0] PREAMBLE_BYTE = 8'h55;
  localparam logic [CRC_W-1:0]  CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0]  CRC_SEED      = '1;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] x;
    x = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (x[0] ^ d[i]) x = (x >> 1) ^ CRC_POLY_REFL;
      else             x = x >> 1;
    end
    return x;
  endfunction

  // Reverse byte order: the first byte to arrive is the low byte of the checksum.
  function automatic logic [CRC_W-1:0] byte_swap(input logic [CRC_W-1:0] w);
    logic [CRC_W-1:0] r;
    for (int b = 0; b < TAIL_BYTES; b++)
      r[b*BYTE_W +: BYTE_W] = w[(TAIL_BYTES-1-b)*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/gmii_rx_hdr.sv
module gmii_rx_hdr
  import gmii_rx_pkg::*;
#(
  parameter int SKIP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_dv,
  input  logic [BYTE_W-1:0] in_d,
  output logic              live,
  output logic              start
);
  localparam int CW = $clog2(SKIP_BYTES + 1);
  localparam logic [CW-1:0] SKIP_C = CW'(SKIP_BYTES);

  logic [CW-1:0] cnt;
  logic          act;

  assign start = in_dv && (cnt == '0) && (in_d == PREAMBLE_BYTE);
  assign live  = in_dv && act && (cnt == SKIP_C);

  always_ff @(posedge clk) begin
    if (rst || !in_dv) begin
      cnt <= '0;
      act <= 1'b0;
    end else begin
      if (cnt == '0) act <= (in_d == PREAMBLE_BYTE);
      if (cnt != SKIP_C) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gmii_rx_dly.sv
module gmii_rx_dly
  import gmii_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_in,
  input  logic [BYTE_W-1:0] d_in,
  output logic              v_out,
  output logic [BYTE_W-1:0] d_out
);
  logic              vq [DEPTH];
  logic [BYTE_W-1:0] dq [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) vq[0] <= 1'b0;
        else     vq[0] <= v_in;
        dq[0] <= d_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) vq[s] <= 1'b0;
        else     vq[s] <= vq[s-1];
        dq[s] <= dq[s-1];
      end
    end
  end

  assign v_out = vq[DEPTH-1];
  assign d_out = dq[DEPTH-1];
endmodule

// File: rtl/gmii_rx_crc.sv
module gmii_rx_crc
  import gmii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (en)     crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/gmii_rx_extract.sv
module gmii_rx_extract
  import gmii_rx_pkg::*;
#(
  parameter int SKIP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_dv,
  input  logic [BYTE_W-1:0] rxd,
  input  logic              ref_en,
  input  logic [BYTE_W-1:0] ref_byte,
  output logic              pld_vld,
  output logic [BYTE_W-1:0] pld_byte,
  output logic              chk_done,
  output logic              crc_err_n,
  output logic              data_err_n,
  output logic              err_n
);
  logic              in_dv;
  logic [BYTE_W-1:0] in_d;
  logic              live, start;
  logic              v_late;
  logic [BYTE_W-1:0] d_late;
  logic              take_pld, take_fcs, fcs_prev, verdict;
  logic [CRC_W-1:0]  crc_acc, fcs_sr;

  always_ff @(posedge clk) begin
    if (rst) in_dv <= 1'b0;
    else     in_dv <= rx_dv;
    in_d <= rxd;
  end

  gmii_rx_hdr #(.SKIP_BYTES(SKIP_BYTES)) u_hdr (
    .clk(clk), .rst(rst), .in_dv(in_dv), .in_d(in_d),
    .live(live), .start(start)
  );

  gmii_rx_dly #(.DEPTH(TAIL_BYTES)) u_dly (
    .clk(clk), .rst(rst), .v_in(live), .d_in(in_d),
    .v_out(v_late), .d_out(d_late)
  );

  assign take_pld = live && v_late;
  assign take_fcs = !live && v_late;
  assign verdict  = fcs_prev && !take_fcs;

  gmii_rx_crc u_crc (
    .clk(clk), .rst(rst), .init(verdict), .en(take_pld),
    .din(d_late), .crc(crc_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fcs_prev <= 1'b0;
      fcs_sr   <= '0;
    end else begin
      fcs_prev <= take_fcs;
      if (take_fcs) fcs_sr <= {fcs_sr[CRC_W-BYTE_W-1:0], d_late};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pld_vld    <= 1'b0;
      chk_done   <= 1'b0;
      crc_err_n  <= 1'b1;
      data_err_n <= 1'b1;
    end else begin
      pld_vld  <= take_pld;
      chk_done <= verdict;
      if (start) begin
        crc_err_n  <= 1'b1;
        data_err_n <= 1'b1;
      end
      if (pld_vld && ref_en && (ref_byte != pld_byte)) data_err_n <= 1'b0;
      if (verdict) crc_err_n <= (byte_swap(fcs_sr) == ~crc_acc);
    end
  end

  always_ff @(posedge clk) pld_byte <= d_late;

  assign err_n = crc_err_n & data_err_n;
endmodule

// File: rtl/gmii_rx_extract_chk.sv
module gmii_rx_extract_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_dv,
  input logic       ref_en,
  input logic       pld_vld,
  input logic       chk_done,
  input logic       crc_err_n,
  input logic       data_err_n,
  input logic       err_n
);
  // R2: a payload byte was on the line with valid high five edges earlier
  a_r2_pld_from_valid: assert property (@(posedge clk) disable iff (rst)
    pld_vld |-> $past(rx_dv, 5));
  // R4: verdict strobe lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    chk_done |=> !chk_done);
  // R4: checksum flag only drops with a verdict
  a_r4_crc_fall_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(crc_err_n) |-> chk_done);
  // R5: data flag only drops after an enabled payload compare
  a_r5_data_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(data_err_n) |-> $past(pld_vld && ref_en));
  // R6: disabled reference cannot lower the data flag
  a_r6_ref_disabled: assert property (@(posedge clk) disable iff (rst)
    (pld_vld && !ref_en) |=> !$fell(data_err_n));
  // R8: checksum flag rises only on a verdict or a frame start
  a_r8_crc_restore: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err_n) |-> (chk_done || $past(rx_dv)));
  // R7: combined flag is never high while a single flag is low
  a_r7_combined: assert property (@(posedge clk) disable iff (rst)
    (!crc_err_n || !data_err_n) |-> !err_n);
endmodule

bind gmii_rx_extract gmii_rx_extract_chk u_chk (
  .clk(clk), .rst(rst), .rx_dv(rx_dv), .ref_en(ref_en),
  .pld_vld(pld_vld), .chk_done(chk_done), .crc_err_n(crc_err_n),
  .data_err_n(data_err_n), .err_n(err_n)
);

// File: tb/tb_gmii_rx_extract.sv
module tb_gmii_rx_extract;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_dv = 1'b0;
  logic [7:0] rxd = 8'h00;
  logic       ref_en = 1'b0;
  logic [7:0] ref_byte = 8'h00;
  logic       pld_vld, chk_done, crc_err_n, data_err_n, err_n;
  logic [7:0] pld_byte;

  gmii_rx_extract dut (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rxd(rxd), .ref_en(ref_en),
    .ref_byte(ref_byte), .pld_vld(pld_vld), .pld_byte(pld_byte),
    .chk_done(chk_done), .crc_err_n(crc_err_n), .data_err_n(data_err_n),
    .err_n(err_n)
  );

  always #5 clk = ~clk;

  // labels: 0 none, 1 payload, 2 first payload, 3 tail byte, 4 last tail byte
  int   lab [0:6];
  logic [7:0] dat [0:6];
  bit   bad [0:6];
  int   p_lab; logic [7:0] p_dat; bit p_bad;
  bit   exp_crc_ok = 1, exp_data_ok = 1;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k]) begin
      c = c ^ {24'h0, b[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // one clock step: check outputs of the last edge, then drive the next byte
  task automatic step(input logic dv, input logic [7:0] d, input int l, input bit bm);
    @(negedge clk);
    for (int i = 6; i > 0; i--) begin lab[i] = lab[i-1]; dat[i] = dat[i-1]; bad[i] = bad[i-1]; end
    lab[0] = p_lab; dat[0] = p_dat; bad[0] = p_bad;
    begin
      bit ep;
      ep = (lab[5] == 1) || (lab[5] == 2);
      chk(pld_vld == ep, "R2/R3 pld_vld", pld_vld, ep);
      if (ep) chk(pld_byte == dat[5], "R2 pld_byte", pld_byte, dat[5]);
      if (lab[5] == 2) chk(crc_err_n && data_err_n, "R8 flags restored", {crc_err_n, data_err_n}, 3);
      chk(chk_done == (lab[6] == 4), "R4 chk_done timing", chk_done, lab[6] == 4);
      if (lab[6] == 4) begin
        chk(crc_err_n == exp_crc_ok, "R4/R10 crc_err_n", crc_err_n, exp_crc_ok);
        chk(data_err_n == exp_data_ok, "R5/R6 data_err_n", data_err_n, exp_data_ok);
        chk(err_n == (exp_crc_ok && exp_data_ok), "R7 err_n", err_n, exp_crc_ok && exp_data_ok);
      end
      ref_byte = ep ? (dat[5] ^ (bad[5] ? 8'h21 : 8'h00)) : 8'hXX;
      if (!ep) ref_byte = 8'h00;
    end
    rx_dv = dv; rxd = d; p_lab = dv ? l : 0; p_dat = d; p_bad = bm;
  endtask

  task automatic send_frame(input int n, input int seed, input bit bad_fcs,
                            input int bad_idx, input bit ren, input bit good_pre);
    logic [7:0] body[$];
    logic [7:0] fr[$];
    logic [31:0] f;
    int len;
    for (int i = 0; i < n; i++) body.push_back(8'((seed * 37 + i * 11 + (i >> 2)) & 8'hFF));
    f = ref_crc(body);
    if (bad_fcs) f = f ^ 32'h0000_8000;
    for (int i = 0; i < 7; i++) fr.push_back(8'h55);
    if (!good_pre) fr[0] = 8'hAA;
    fr.push_back(8'hD5);
    foreach (body[k]) fr.push_back(body[k]);
    for (int b = 0; b < 4; b++) fr.push_back(f[b*8 +: 8]);
    len = fr.size();
    if (good_pre) begin
      exp_crc_ok = !bad_fcs;
      exp_data_ok = !((bad_idx >= 0) && ren);
    end
    ref_en = ren;
    for (int i = 0; i < len; i++) begin
      int l;
      l = 0;
      if (good_pre && i >= 8) begin
        if (i == len - 1) l = 4;
        else if (i >= len - 4) l = 3;
        else if (i == 8) l = 2;
        else l = 1;
      end
      step(1'b1, fr[i], l, (i - 8) == bad_idx);
    end
    for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) begin lab[i] = 0; dat[i] = 0; bad[i] = 0; end
    p_lab = 0; p_dat = 0; p_bad = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!pld_vld && !chk_done, "R9 strobes low", {pld_vld, chk_done}, 0);
    chk(crc_err_n && data_err_n && err_n, "R9 flags high", {crc_err_n, data_err_n, err_n}, 7);
    send_frame(60, 1, 0, -1, 1, 1);   // R2 R4 good frame
    send_frame(46, 2, 1, -1, 1, 1);   // R4 corrupted checksum
    send_frame(50, 3, 0, 10, 1, 1);   // R5 reference mismatch
    send_frame(20, 4, 0, 5, 0, 1);    // R6 mismatch with compare disabled
    send_frame(0, 5, 0, -1, 1, 1);    // R10 R3 empty payload
    send_frame(33, 6, 0, -1, 1, 0);   // R1 frame without 0x55 start
    send_frame(1, 7, 1, 0, 1, 1);     // R3 R5 R7 one payload byte, both errors
    send_frame(64, 8, 0, -1, 1, 1);   // R8 recovery after errors
    send_frame(5, 9, 0, 4, 1, 1);     // R5 last payload byte mismatched
    send_frame(70, 10, 0, -1, 1, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule